// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Unit

This unit sits next to the sequencer of a small 4-bit processor and decides, at each instruction boundary, whether a pending interrupt request is taken. It watches up to fifteen request lines and a global interrupt-enable flag that it owns. It also watches strobes from the decoder that mark a completing instruction as an enable, a disable or a page-set, and a level that says the core is halted or sleeping. When it accepts a request, it raises a one-cycle take strobe in the same cycle as the boundary. In that cycle it presents the vector address and tells the sequencer to force the next-page register to 1. If the core was halted or sleeping, it also raises a wake signal.

The vector address stays in the bank that is executing. It points at page 1, with a step equal to the vector number. After a take, the unit clears its enable flag. It then drives the return address, which is the page nibble plus the step byte the sequencer presents during the take cycle, as three consecutive 4-bit stack writes. Enabling takes effect one instruction late. Disabling takes effect at once. A page-set instruction is never separated from the branch that follows it. Registers and other flags belong to the core and are not touched.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the enable output `ien` is 0, `take` is 0 and `push_we` is 0.
- R2: With `ien` = 1 and at least one request pending, a cycle with `insn_done` = 1 raises `take` in that same cycle. In that cycle `npp_set` = 1, `vec_num` is the vector taken and `vec_addr` = {`cur_bank`, 4'h1, 8-bit vector number}, with the page nibble in bits [11:8].
- R3: Bit i of `irq_req` requests vector i+1. When several bits are set, the lowest-numbered vector is taken.
- R4: A boundary whose completing instruction has `dec_di` = 1 never takes, and `ien` reads 0 from the next cycle on.
- R5: A boundary with `dec_ei` = 1 sets `ien` from the next cycle on. If `ien` was 0, that boundary does not take, and the next boundary with a pending request does take.
- R6: A take clears `ien` from the next cycle on. An enable inside the service routine sets it again, so a further take can follow (nesting).
- R7: A boundary with `dec_pset` = 1 never takes. The following boundary, which completes the branch, may take.
- R8: While `halted` = 1, `ien` = 1 and a request is pending, `take` and `wake` are 1 without any `insn_done`. While `halted` = 1 and `ien` = 0, both stay 0.
- R9: During the three cycles after a take, `push_we` = 1 and `push_data` carries, in order, `pc_page`, `pc_step`[7:4] and `pc_step`[3:0] as sampled in the take cycle. `push_we` is 0 in the fourth cycle.
- R10: No take occurs while `push_we` = 1, even at an enabled boundary with a request pending.
- R11: Requests are ignored when `insn_done` = 0 and `halted` = 0: `take` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 15 | Pending request lines, bit i = vector i+1 |
| insn_done | input | 1 | Instruction boundary strobe |
| dec_ei | input | 1 | Completing instruction sets the enable flag |
| dec_di | input | 1 | Completing instruction clears the enable flag |
| dec_pset | input | 1 | Completing instruction is a page-set |
| halted | input | 1 | Core is in halt or sleep |
| cur_bank | input | 1 | Bank currently executing |
| pc_page | input | 4 | Page part of the return address |
| pc_step | input | 8 | Step part of the return address |
| take | output | 1 | Interrupt accepted this cycle |
| npp_set | output | 1 | Force next-page register to 1 |
| wake | output | 1 | Restart core from halt or sleep |
| vec_num | output | 4 | Vector number being taken |
| vec_addr | output | 13 | Vector address {bank, page, step} |
| ien | output | 1 | Global interrupt enable flag |
| push_we | output | 1 | Stack write strobe |
| push_data | output | 4 | Stack write nibble |

## Verification
The main collisions are between a decoded flag or page-set event and a pending request at the same boundary. The bench provokes them by presenting requests together with the enable, disable or page-set strobe. It then checks that the boundary itself does not take, and that the following boundary takes only in the enable and page-set cases. A second collision is a new boundary during the three-cycle return-address push. The bench re-enables inside the push and offers a request, expecting no take until the push ends. A sweep of request patterns compares the vector against the lowest set bit computed in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int PAGE_W   = 4;
   localparam int STEP_W   = 8;
   localparam int NIB_W    = 4;
   localparam int RET_W    = PAGE_W + STEP_W;
   localparam int PUSH_N   = RET_W / NIB_W;
   localparam int MAX_VEC  = 15;
   localparam logic [PAGE_W-1:0] VEC_PAGE = 4'h1;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_VEC   = 15,
   parameter bit LOW_FIRST = 1'b1,
   parameter int VN_W      = 4
) (
   input  logic [NUM_VEC-1:0] req,
   output logic               any,
   output logic [VN_W-1:0]    idx
);
   assign any = |req;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = NUM_VEC - 1; i >= 0; i--) begin
               if (req[i]) idx = VN_W'(i + 1);
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < NUM_VEC; i++) begin
               if (req[i]) idx = VN_W'(i + 1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic boundary,
   input  logic set_req,
   input  logic clr_req,
   input  logic take,
   output logic ien
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien <= 1'b0;
      end else if (take) begin
         ien <= 1'b0;
      end else if (boundary && clr_req) begin
         ien <= 1'b0;
      end else if (boundary && set_req) begin
         ien <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_push_seq.sv
module irq_push_seq
   import irq_pkg::*;
#(
   parameter int RW = RET_W,
   parameter int NW = NIB_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [RW-1:0] ret,
   output logic          we,
   output logic [NW-1:0] data
);
   localparam int N   = RW / NW;
   localparam int CW  = $clog2(N + 1);

   logic [RW-1:0] sh;
   logic [CW-1:0] cnt;

   initial begin
      assert (RW % NW == 0) else $error("return width must be a whole number of nibbles");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (start) begin
         sh  <= ret;
         cnt <= CW'(N);
      end else if (cnt != '0) begin
         sh  <= sh << NW;
         cnt <= cnt - CW'(1);
      end
   end

   assign we   = (cnt != '0);
   assign data = sh[RW-1 -: NW];
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
   import irq_pkg::*;
#(
   parameter int NUM_VEC   = 15,
   parameter int BANK_W    = 1,
   parameter bit LOW_FIRST = 1'b1,
   parameter int VN_W      = $clog2(NUM_VEC + 1),
   parameter int ADDR_W    = BANK_W + PAGE_W + STEP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] irq_req,
   input  logic               insn_done,
   input  logic               dec_ei,
   input  logic               dec_di,
   input  logic               dec_pset,
   input  logic               halted,
   input  logic [BANK_W-1:0]  cur_bank,
   input  logic [PAGE_W-1:0]  pc_page,
   input  logic [STEP_W-1:0]  pc_step,
   output logic               take,
   output logic               npp_set,
   output logic               wake,
   output logic [VN_W-1:0]    vec_num,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic               ien,
   output logic               push_we,
   output logic [NIB_W-1:0]   push_data
);
   initial begin
      assert (NUM_VEC >= 1 && NUM_VEC <= MAX_VEC) else $error("NUM_VEC out of range");
      assert (BANK_W >= 1) else $error("BANK_W must be at least 1");
      assert (VN_W <= STEP_W) else $error("vector number wider than step field");
   end

   logic any_req;
   logic [VN_W-1:0] idx;
   logic boundary_ok;
   logic blocked;

   irq_prio_enc #(
      .NUM_VEC  (NUM_VEC),
      .LOW_FIRST(LOW_FIRST),
      .VN_W     (VN_W)
   ) u_prio (
      .req(irq_req),
      .any(any_req),
      .idx(idx)
   );

   // halted cores have no boundary strobe; the halt state itself is a boundary
   assign boundary_ok = insn_done || halted;
   // disable acts on its own step; page-set keeps its branch partner atomic
   assign blocked     = (insn_done && (dec_di || dec_pset)) || push_we;
   assign take        = boundary_ok && ien && any_req && !blocked;

   irq_flag_ctl u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .boundary(insn_done),
      .set_req (dec_ei),
      .clr_req (dec_di),
      .take    (take),
      .ien     (ien)
   );

   irq_push_seq #(
      .RW(RET_W),
      .NW(NIB_W)
   ) u_push (
      .clk  (clk),
      .rst_n(rst_n),
      .start(take),
      .ret  ({pc_page, pc_step}),
      .we   (push_we),
      .data (push_data)
   );

   assign npp_set  = take;
   assign wake     = take && halted;
   assign vec_num  = idx;
   assign vec_addr = {cur_bank, VEC_PAGE, STEP_W'(idx)};
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
   import irq_pkg::*;
#(
   parameter int NUM_VEC = 15,
   parameter int BANK_W  = 1,
   parameter int ADDR_W  = BANK_W + PAGE_W + STEP_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_VEC-1:0] irq_req,
   input logic               insn_done,
   input logic               dec_di,
   input logic               dec_pset,
   input logic               halted,
   input logic               take,
   input logic               wake,
   input logic [ADDR_W-1:0]  vec_addr,
   input logic               ien,
   input logic               push_we
);
   p_take_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (ien && (irq_req != '0)));

   p_vector_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (vec_addr[STEP_W +: PAGE_W] == VEC_PAGE));

   p_di_same_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done && dec_di) |-> !take);

   p_di_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done && dec_di) |=> !ien);

   p_take_clears_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !ien);

   p_pset_atomic_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done && dec_pset) |-> !take);

   p_wake_from_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (take && halted));

   p_push_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> push_we);

   p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push_we |-> !take);

   p_idle_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!insn_done && !halted) |-> !take);
endmodule

bind irq_accept_unit irq_accept_chk #(
   .NUM_VEC(NUM_VEC),
   .BANK_W (BANK_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_req  (irq_req),
   .insn_done(insn_done),
   .dec_di   (dec_di),
   .dec_pset (dec_pset),
   .halted   (halted),
   .take     (take),
   .wake     (wake),
   .vec_addr (vec_addr),
   .ien      (ien),
   .push_we  (push_we)
);

// File: tb/irq_accept_unit_test.sv
`timescale 1ns/100ps
module irq_accept_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] irq_req = '0;
   logic        insn_done = 1'b0, dec_ei = 1'b0, dec_di = 1'b0, dec_pset = 1'b0;
   logic        halted = 1'b0;
   logic        cur_bank = 1'b0;
   logic [3:0]  pc_page = '0;
   logic [7:0]  pc_step = '0;
   logic        take, npp_set, wake, ien, push_we;
   logic [3:0]  vec_num, push_data;
   logic [12:0] vec_addr;

   int  n_run = 0, n_fail = 0;
   bit  done = 0;
   logic        s_take, s_npp;
   logic [3:0]  s_vn;
   logic [12:0] s_va;

   always #2.5 clk = ~clk;

   irq_accept_unit uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_done(insn_done),
      .dec_ei(dec_ei), .dec_di(dec_di), .dec_pset(dec_pset), .halted(halted),
      .cur_bank(cur_bank), .pc_page(pc_page), .pc_step(pc_step),
      .take(take), .npp_set(npp_set), .wake(wake), .vec_num(vec_num),
      .vec_addr(vec_addr), .ien(ien), .push_we(push_we), .push_data(push_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lowest(input logic [14:0] r);
      for (int i = 0; i < 15; i++) if (r[i]) return i + 1;
      return 0;
   endfunction

   // one instruction boundary; samples the combinational outputs mid-cycle
   task automatic bnd(input logic [14:0] rq, input logic di, input logic ei, input logic ps);
      irq_req = rq; insn_done = 1'b1; dec_di = di; dec_ei = ei; dec_pset = ps;
      @(negedge clk);
      s_take = take; s_vn = vec_num; s_va = vec_addr; s_npp = npp_set;
      @(posedge clk); #1;
      insn_done = 1'b0; dec_di = 1'b0; dec_ei = 1'b0; dec_pset = 1'b0;
   endtask

   task automatic chk_push(input logic [3:0] pg, input logic [7:0] st, input string tag);
      @(negedge clk);
      chk(push_we && push_data == pg, {tag, " R9 page nibble"}, {push_we, push_data}, {1'b1, pg});
      chk(ien == 1'b0, {tag, " R6 flag cleared"}, ien, 0);
      @(negedge clk);
      chk(push_we && push_data == st[7:4], {tag, " R9 step high"}, {push_we, push_data}, {1'b1, st[7:4]});
      @(negedge clk);
      chk(push_we && push_data == st[3:0], {tag, " R9 step low"}, {push_we, push_data}, {1'b1, st[3:0]});
      @(negedge clk);
      chk(!push_we, {tag, " R9 push ends"}, push_we, 0);
      @(posedge clk); #1;
   endtask

   task automatic take_case(input logic [14:0] rq, input logic bk, input logic [3:0] pg,
                            input logic [7:0] st, input string tag);
      int e;
      e = lowest(rq);
      bnd('0, 1'b0, 1'b1, 1'b0);
      cur_bank = bk; pc_page = pg; pc_step = st;
      bnd(rq, 1'b0, 1'b0, 1'b0);
      irq_req = '0;
      chk(s_take && s_npp, {tag, " R2 take and npp"}, {s_take, s_npp}, 3);
      chk(s_vn == 4'(e), {tag, " R3 vector"}, s_vn, e);
      chk(s_va == {bk, 4'h1, 8'(e)}, {tag, " R2 vector address"}, s_va, {bk, 4'h1, 8'(e)});
      chk_push(pg, st, tag);
   endtask

   initial begin
      #(5 * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!ien && !take && !push_we, "R1 reset state", {ien, take, push_we}, 0);

      // R11: requests between boundaries and while disabled
      irq_req = 15'h7fff;
      repeat (3) begin
         @(negedge clk);
         chk(!take, "R11 no boundary no take", take, 0);
      end
      @(posedge clk); #1;
      bnd(15'h7fff, 1'b0, 1'b0, 1'b0);
      chk(!s_take, "R2 disabled boundary no take", s_take, 0);

      // R5: enable with a pending request delays by exactly one instruction
      pc_page = 4'h6; pc_step = 8'h9c; cur_bank = 1'b1;
      bnd(15'h0010, 1'b0, 1'b1, 1'b0);
      chk(!s_take, "R5 enable step itself", s_take, 0);
      @(negedge clk);
      chk(ien, "R5 flag set after enable", ien, 1);
      @(posedge clk); #1;
      bnd(15'h0010, 1'b0, 1'b0, 1'b0);
      irq_req = '0;
      chk(s_take && s_vn == 4'd5, "R5 take on next step", {s_take, s_vn}, {1'b1, 4'd5});
      chk_push(4'h6, 8'h9c, "R5");

      // R4: disable blocks on the same step
      bnd('0, 1'b0, 1'b1, 1'b0);
      bnd(15'h0001, 1'b1, 1'b0, 1'b0);
      chk(!s_take, "R4 disable same step", s_take, 0);
      @(negedge clk);
      chk(!ien, "R4 flag cleared", ien, 0);
      @(posedge clk); #1;
      bnd(15'h0001, 1'b0, 1'b0, 1'b0);
      chk(!s_take, "R4 stays blocked", s_take, 0);
      irq_req = '0;

      // R7: page-set and branch pair is never split, for every line
      for (int v = 1; v <= 15; v++) begin
         bnd('0, 1'b0, 1'b1, 1'b0);
         bnd(15'(1 << (v - 1)), 1'b0, 1'b0, 1'b1);
         chk(!s_take, "R7 page-set step", s_take, 0);
         pc_page = 4'(v); pc_step = 8'(v * 11);
         bnd(15'(1 << (v - 1)), 1'b0, 1'b0, 1'b0);
         irq_req = '0;
         chk(s_take && s_vn == 4'(v), "R7 take after branch", {s_take, s_vn}, {1'b1, 4'(v)});
         chk_push(4'(v), 8'(v * 11), "R7");
      end

      // R6: nesting by re-enabling inside the handler
      take_case(15'h0100, 1'b0, 4'h3, 8'h41, "R6 outer");
      bnd(15'h0004, 1'b0, 1'b1, 1'b0);
      chk(!s_take, "R6 enable step in handler", s_take, 0);
      bnd(15'h0004, 1'b0, 1'b0, 1'b0);
      irq_req = '0;
      chk(s_take && s_vn == 4'd3, "R6 nested take", {s_take, s_vn}, {1'b1, 4'd3});
      chk_push(4'h3, 8'h41, "R6 nested");

      // R10: boundaries during the return-address push
      bnd('0, 1'b0, 1'b1, 1'b0);
      bnd(15'h0002, 1'b0, 1'b0, 1'b0);
      chk(s_take, "R10 first take", s_take, 1);
      bnd(15'h0002, 1'b0, 1'b1, 1'b0);
      bnd(15'h0002, 1'b0, 1'b0, 1'b0);
      chk(!s_take, "R10 blocked while pushing", s_take, 0);
      bnd(15'h0002, 1'b0, 1'b0, 1'b0);
      chk(!s_take, "R10 blocked last push", s_take, 0);
      bnd(15'h0002, 1'b0, 1'b0, 1'b0);
      irq_req = '0;
      chk(s_take && s_vn == 4'd2, "R10 take after push", {s_take, s_vn}, {1'b1, 4'd2});
      repeat (4) @(posedge clk);
      #1;

      // R8: wake from halt or sleep
      halted = 1'b1; irq_req = 15'h0040;
      @(negedge clk);
      chk(!take && !wake, "R8 disabled halt stays", {take, wake}, 0);
      @(posedge clk); #1;
      halted = 1'b0; irq_req = '0;
      bnd('0, 1'b0, 1'b1, 1'b0);
      halted = 1'b1;
      @(negedge clk);
      chk(!take && !wake, "R8 halt no request", {take, wake}, 0);
      @(posedge clk); #1;
      irq_req = 15'h0040; pc_page = 4'hb; pc_step = 8'h27;
      @(negedge clk);
      chk(take && wake && vec_num == 4'd7, "R8 wake and take", {take, wake, vec_num}, {2'b11, 4'd7});
      @(posedge clk); #1;
      halted = 1'b0; irq_req = '0;
      chk_push(4'hb, 8'h27, "R8");

      // R3: sweep of request patterns against the lowest set bit
      for (int r = 1; r < 32768; r += 13) begin
         take_case(15'(r), r[0], 4'(r >> 3), 8'(r * 7), "R3 sweep");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule